// File: doc/BRIEF.md
# Four-Channel DMA Transfer Sequencer

This block runs direct memory transfers for four channels once each channel's start address, byte count and mode have been written in. It watches the per-channel peripheral requests and picks one channel by priority. It then asks the host for the bus and waits for the host to grant it. Only after the grant does it return an acknowledge to the chosen channel and run the byte cycles. Each byte cycle presents a 16-bit address. The low half goes on dedicated address lines. The high half goes on the shared data lines for one strobed cycle, so that an external latch can capture it.

Each channel runs in one of four modes. A channel can move one byte per bus grant, a whole count in one grant, or bytes only for as long as its request stays high. It can also act as a pass-through that forwards a downstream controller's bus request and grant. A separate memory-copy path uses channel 0 as the source pointer and channel 1 as the destination pointer and counter. An optional setting freezes the source pointer, which fills a region with a single byte. A transfer ends when the count runs out or when the external end input is raised. Priority between channels is either fixed or rotating.

Top module: `dma_xfer_seq`

## Requirements
- R1: An eligible request seen with the block idle raises `hrq` on the next cycle. `dack` stays low until the cycle after `hlda` is sampled high, and `hrq` stays high until the channel's service ends.
- R2: In every address cycle `adstb` is high, `addr_lo` carries address bits 7:0, and `data_out` carries bits 15:8 with `data_oe` high.
- R3: Mode 2'b01 (single) moves exactly one byte per grant. `hrq` falls after each byte, and a held request is granted again.
- R4: Mode 2'b10 (block) moves count+1 bytes at rising addresses within a single grant, whatever the request does meanwhile.
- R5: Mode 2'b00 (demand) keeps moving bytes while the request is high. It releases the bus at the first byte that ends with the request low, and it resumes at the next address when the request returns.
- R6: `eop_in` high during a byte cycle makes that byte the last. The channel then ignores requests until reprogrammed, and its `tc_flags` bit stays clear.
- R7: The count drops by one per byte. The byte moved with count 0 is the last one. `eop_out` is high during that byte's strobe cycle, the channel's `tc_flags` bit is set, and the channel ignores requests until a `cfg_we` write to it.
- R8: With rotation off, the lowest-numbered eligible channel wins.
- R9: With rotation on, the channel just served becomes the lowest priority.
- R10: A channel with its `chan_mask` bit set, or any channel while `en` is low, never causes `hrq`.
- R11: Mode 2'b11 (cascade) holds `hrq` and the channel's `dack` high from grant until its request falls. It produces no `adstb` and no read or write strobe.
- R12: With `m2m_en` set, a request on channel 0 copies bytes. Each byte is read at channel 0's address and written at channel 1's address with the value read. Channel 1's count ends the run and sets `tc_flags[1]`.
- R13: With `m2m_en` and `src_hold` set, the source address stays fixed for the whole run.
- R14: `cfg_to_mem`=1 pairs `io_rd` with `mem_wr` in the strobe cycle. `cfg_to_mem`=0 pairs `mem_rd` with `io_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load one channel's settings, clearing its done and terminal flags |
| cfg_ch | input | 2 | Channel written by `cfg_we` |
| cfg_addr | input | 16 | Start address |
| cfg_count | input | 16 | Byte count minus one |
| cfg_mode | input | 2 | 00 demand, 01 single, 10 block, 11 cascade |
| cfg_to_mem | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| en | input | 1 | Controller enable |
| rotate_en | input | 1 | Rotating priority |
| m2m_en | input | 1 | Memory copy using channels 0 and 1 |
| src_hold | input | 1 | Freeze the copy source address |
| chan_mask | input | 4 | Per-channel request mask |
| dreq | input | 4 | Peripheral requests |
| hlda | input | 1 | Bus granted by host |
| eop_in | input | 1 | External end of transfer |
| data_in | input | 8 | Read data for memory copy |
| hrq | output | 1 | Bus request to host |
| dack | output | 4 | Per-channel acknowledge |
| addr_lo | output | 8 | Address bits 7:0 |
| data_out | output | 8 | Address bits 15:8 in the strobe cycle, copy data in the write cycle |
| data_oe | output | 1 | `data_out` is driven |
| adstb | output | 1 | High-address strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| eop_out | output | 1 | Terminal count pulse |
| tc_flags | output | 4 | Sticky per-channel terminal-count flags |

## Verification
`hrq` is due one cycle after an eligible request is seen while idle. `dack` and the first address strobe are due one cycle after `hlda` is sampled high, and the peripheral strobes follow one cycle later. Each peripheral byte therefore takes two cycles and each copied byte takes four. The handshake checks sample at falling edges counted from the cycle that raised the request. Checks on whole runs record every strobed address and every strobe cycle at the falling edge, let the run settle, and then compare the logged sequence, the channel order and the flags with values worked out from the programmed start addresses and counts.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    MD_DEMAND  = 2'b00,
    MD_SINGLE  = 2'b01,
    MD_BLOCK   = 2'b10,
    MD_CASCADE = 2'b11
  } xfer_mode_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_HOLD,
    S_ADDR,
    S_XFER,
    S_CASC,
    S_MSA,
    S_MRD,
    S_MDA,
    S_MWR,
    S_REL
  } seq_state_e;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_cnt,
  input  xfer_mode_e    ld_mode,
  input  logic          ld_to_mem,
  input  logic          step_addr,
  input  logic          step_cnt,
  input  logic          mark_done,
  input  logic          mark_tc,
  output logic [AW-1:0] cur_addr,
  output xfer_mode_e    mode,
  output logic          to_mem,
  output logic          done,
  output logic          tc_flag,
  output logic          cnt_zero
);

  logic [CW-1:0] cur_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
      mode     <= MD_SINGLE;
      to_mem   <= 1'b0;
      done     <= 1'b0;
      tc_flag  <= 1'b0;
    end else if (load) begin
      cur_addr <= ld_addr;
      cur_cnt  <= ld_cnt;
      mode     <= ld_mode;
      to_mem   <= ld_to_mem;
      done     <= 1'b0;
      tc_flag  <= 1'b0;
    end else begin
      if (step_addr) cur_addr <= cur_addr + AW'(1);
      if (step_cnt)  cur_cnt  <= cur_cnt - CW'(1);
      if (mark_done) done     <= 1'b1;
      if (mark_tc)   tc_flag  <= 1'b1;
    end
  end

  assign cnt_zero = (cur_cnt == '0);

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> done); // R7

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step_cnt && !load && cnt_zero) |=> (&cur_cnt)); // R7

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4,
  localparam int IW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  input  logic [IW-1:0]  base,
  output logic           valid,
  output logic [IW-1:0]  idx
);

  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int k = 0; k < NCH; k++) begin
      logic [IW-1:0] j;
      j = base + IW'(k);
      if (!valid && req[j]) begin
        valid = 1'b1;
        idx   = j;
      end
    end
  end

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  localparam int IW = $clog2(NCH),
  localparam int LW = AW / 2,
  localparam int HW = AW - LW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] dreq,
  input  logic           hlda,
  input  logic           eop_in,
  input  logic           rotate_en,
  input  logic           m2m_en,
  input  logic           src_hold,
  input  logic [HW-1:0]  data_in,
  input  logic           pick_valid,
  input  logic [IW-1:0]  pick_idx,
  input  logic [AW-1:0]  ch_addr [NCH],
  input  xfer_mode_e     ch_mode [NCH],
  input  logic [NCH-1:0] ch_to_mem,
  input  logic [NCH-1:0] ch_zero,
  output logic [IW-1:0]  prio_base,
  output logic           hrq,
  output logic [NCH-1:0] dack,
  output logic [LW-1:0]  addr_lo,
  output logic [HW-1:0]  data_out,
  output logic           data_oe,
  output logic           adstb,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           io_rd,
  output logic           io_wr,
  output logic           eop_out,
  output logic [NCH-1:0] step_addr,
  output logic [NCH-1:0] step_cnt,
  output logic [NCH-1:0] mark_done,
  output logic [NCH-1:0] mark_tc
);

  seq_state_e    st;
  logic [IW-1:0] ch;
  logic [HW-1:0] temp;
  logic [AW-1:0] sel_addr;
  logic          xfer_end;
  logic          copy_end;
  logic [IW-1:0] next_base;

  assign next_base = rotate_en ? ch + IW'(1) : '0;

  always_comb begin
    xfer_end = ch_zero[ch] || eop_in || (ch_mode[ch] == MD_SINGLE) ||
               ((ch_mode[ch] == MD_DEMAND) && !dreq[ch]);
    copy_end = ch_zero[1] || eop_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      ch        <= '0;
      temp      <= '0;
      prio_base <= '0;
    end else begin
      case (st)
        S_IDLE: if (pick_valid) begin
          ch <= pick_idx;
          st <= S_HOLD;
        end
        S_HOLD: if (hlda) begin
          if (ch_mode[ch] == MD_CASCADE)  st <= S_CASC;
          else if (m2m_en && ch == '0)    st <= S_MSA;
          else                            st <= S_ADDR;
        end
        S_ADDR: st <= S_XFER;
        S_XFER: if (xfer_end) begin
          st        <= S_REL;
          prio_base <= next_base;
        end else begin
          st <= S_ADDR;
        end
        S_CASC: if (!dreq[ch]) begin
          st        <= S_REL;
          prio_base <= next_base;
        end
        S_MSA: st <= S_MRD;
        S_MRD: begin
          temp <= data_in;
          st   <= S_MDA;
        end
        S_MDA: st <= S_MWR;
        S_MWR: if (copy_end) begin
          st        <= S_REL;
          prio_base <= next_base;
        end else begin
          st <= S_MSA;
        end
        S_REL:   if (!hlda) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    sel_addr  = ch_addr[ch];
    if (st == S_MSA || st == S_MRD) sel_addr = ch_addr[0];
    if (st == S_MDA || st == S_MWR) sel_addr = ch_addr[1];

    hrq       = !(st == S_IDLE || st == S_REL);
    dack      = '0;
    if (st == S_ADDR || st == S_XFER || st == S_CASC) dack[ch] = 1'b1;
    adstb     = (st == S_ADDR) || (st == S_MSA) || (st == S_MDA);
    addr_lo   = (st == S_ADDR || st == S_XFER || st == S_MSA ||
                 st == S_MRD || st == S_MDA || st == S_MWR) ? sel_addr[LW-1:0] : '0;
    data_oe   = adstb || (st == S_MWR);
    data_out  = adstb ? sel_addr[AW-1:LW] : ((st == S_MWR) ? temp : '0);
    io_rd     = (st == S_XFER) && ch_to_mem[ch];
    io_wr     = (st == S_XFER) && !ch_to_mem[ch];
    mem_wr    = io_rd || (st == S_MWR);
    mem_rd    = io_wr || (st == S_MRD);
    eop_out   = ((st == S_XFER) && ch_zero[ch]) || ((st == S_MWR) && ch_zero[1]);

    step_addr = '0;
    step_cnt  = '0;
    mark_done = '0;
    mark_tc   = '0;
    if (st == S_XFER) begin
      step_addr[ch] = 1'b1;
      step_cnt[ch]  = 1'b1;
      if (ch_zero[ch]) begin
        mark_tc[ch]   = 1'b1;
        mark_done[ch] = 1'b1;
      end else if (eop_in) begin
        mark_done[ch] = 1'b1;
      end
    end
    if (st == S_MWR) begin
      step_addr[1] = 1'b1;
      step_cnt[1]  = 1'b1;
      if (!src_hold) step_addr[0] = 1'b1;
      if (copy_end) begin
        mark_done[0] = 1'b1;
        mark_done[1] = 1'b1;
        mark_tc[1]   = ch_zero[1];
      end
    end
  end

  AST_DACK_AFTER_HLDA: assert property (@(posedge clk) disable iff (rst)
    $rose(|dack) |-> $past(hlda)); // R1

  AST_DACK_NEEDS_HRQ: assert property (@(posedge clk) disable iff (rst)
    (|dack) |-> hrq); // R1

  AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dack)); // R8

  AST_ADSTB_ON_GRANT: assert property (@(posedge clk) disable iff (rst)
    adstb |-> $past(hlda)); // R2

  AST_EOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    eop_out |=> !hrq); // R7

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  localparam int IW = $clog2(NCH),
  localparam int LW = AW / 2,
  localparam int HW = AW - LW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_ch,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [CW-1:0]  cfg_count,
  input  logic [1:0]     cfg_mode,
  input  logic           cfg_to_mem,
  input  logic           en,
  input  logic           rotate_en,
  input  logic           m2m_en,
  input  logic           src_hold,
  input  logic [NCH-1:0] chan_mask,
  input  logic [NCH-1:0] dreq,
  input  logic           hlda,
  input  logic           eop_in,
  input  logic [HW-1:0]  data_in,
  output logic           hrq,
  output logic [NCH-1:0] dack,
  output logic [LW-1:0]  addr_lo,
  output logic [HW-1:0]  data_out,
  output logic           data_oe,
  output logic           adstb,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           io_rd,
  output logic           io_wr,
  output logic           eop_out,
  output logic [NCH-1:0] tc_flags
);

  logic [AW-1:0]  ch_addr [NCH];
  xfer_mode_e     ch_mode [NCH];
  logic [NCH-1:0] ch_to_mem, ch_zero, ch_done, elig;
  logic [NCH-1:0] step_addr, step_cnt, mark_done, mark_tc;
  logic [IW-1:0]  prio_base, pick_idx;
  logic           pick_valid;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .load      (cfg_we && (cfg_ch == IW'(i))),
      .ld_addr   (cfg_addr),
      .ld_cnt    (cfg_count),
      .ld_mode   (xfer_mode_e'(cfg_mode)),
      .ld_to_mem (cfg_to_mem),
      .step_addr (step_addr[i]),
      .step_cnt  (step_cnt[i]),
      .mark_done (mark_done[i]),
      .mark_tc   (mark_tc[i]),
      .cur_addr  (ch_addr[i]),
      .mode      (ch_mode[i]),
      .to_mem    (ch_to_mem[i]),
      .done      (ch_done[i]),
      .tc_flag   (tc_flags[i]),
      .cnt_zero  (ch_zero[i])
    );
    assign elig[i] = en && dreq[i] && !chan_mask[i] && !ch_done[i] &&
                     !(m2m_en && i == 1);
  end

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .req   (elig),
    .base  (prio_base),
    .valid (pick_valid),
    .idx   (pick_idx)
  );

  dma_seq_fsm #(.NCH(NCH), .AW(AW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .dreq       (dreq),
    .hlda       (hlda),
    .eop_in     (eop_in),
    .rotate_en  (rotate_en),
    .m2m_en     (m2m_en),
    .src_hold   (src_hold),
    .data_in    (data_in),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx),
    .ch_addr    (ch_addr),
    .ch_mode    (ch_mode),
    .ch_to_mem  (ch_to_mem),
    .ch_zero    (ch_zero),
    .prio_base  (prio_base),
    .hrq        (hrq),
    .dack       (dack),
    .addr_lo    (addr_lo),
    .data_out   (data_out),
    .data_oe    (data_oe),
    .adstb      (adstb),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .eop_out    (eop_out),
    .step_addr  (step_addr),
    .step_cnt   (step_cnt),
    .mark_done  (mark_done),
    .mark_tc    (mark_tc)
  );

  AST_HRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(hrq) |-> $past(|elig)); // R10

  AST_SRC_FIXED: assert property (@(posedge clk) disable iff (rst)
    (m2m_en && src_hold && hrq && !cfg_we) |=> $stable(ch_addr[0])); // R13

endmodule

// File: tb/dma_xfer_seq_tb.sv
module dma_xfer_seq_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [15:0] cfg_addr = '0, cfg_count = '0;
  logic [1:0]  cfg_mode = '0;
  logic        cfg_to_mem = 1'b0;
  logic        en = 1'b1, rotate_en = 1'b0, m2m_en = 1'b0, src_hold = 1'b0;
  logic [3:0]  chan_mask = '0, dreq_tb = '0, dreq;
  logic        hlda, eop_in = 1'b0;
  logic [7:0]  data_in;
  logic        hrq, data_oe, adstb, mem_rd, mem_wr, io_rd, io_wr, eop_out;
  logic [3:0]  dack, tc_flags;
  logic [7:0]  addr_lo, data_out;

  always #(CLK_NS / 2) clk = ~clk;

  always_ff @(posedge clk) hlda <= rst ? 1'b0 : hrq;

  // monitor state
  logic [15:0] lat_addr = '0;
  logic [15:0] io_addr [256];
  int          io_ch [256];
  logic [15:0] src_a [64], dst_a [64];
  logic [7:0]  dst_d [64];
  int n_io = 0, n_src = 0, n_dst = 0, n_eop = 0, n_stb = 0, n_rise = 0, n_rdio = 0;
  int stop_n = 0;
  logic kill = 1'b0, prev_hrq = 1'b0;

  assign dreq    = dreq_tb & ~{3'b000, kill};
  assign data_in = lat_addr[7:0] ^ 8'h5A;

  always @(negedge clk) begin
    logic [15:0] a;
    a = lat_addr;
    if (adstb) begin
      a = {data_out, addr_lo};
      lat_addr <= a;
      n_stb++;
    end
    if (io_rd || io_wr) begin
      int c;
      c = -1;
      for (int i = 0; i < 4; i++) if (dack[i]) c = i;
      io_addr[n_io] = a;
      io_ch[n_io]   = c;
      n_io++;
      if (io_wr && mem_rd) n_rdio++;
    end
    if (mem_rd && !io_wr) begin src_a[n_src] = a; n_src++; end
    if (mem_wr && !io_rd) begin dst_a[n_dst] = a; dst_d[n_dst] = data_out; n_dst++; end
    if (eop_out) n_eop++;
    if (hrq && !prev_hrq) n_rise++;
    prev_hrq <= hrq;
    if (stop_n == 0) kill <= 1'b0;
    else if (n_io >= stop_n) kill <= 1'b1;
  end

  dma_xfer_seq u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_addr(cfg_addr),
    .cfg_count(cfg_count), .cfg_mode(cfg_mode), .cfg_to_mem(cfg_to_mem), .en(en),
    .rotate_en(rotate_en), .m2m_en(m2m_en), .src_hold(src_hold), .chan_mask(chan_mask),
    .dreq(dreq), .hlda(hlda), .eop_in(eop_in), .data_in(data_in), .hrq(hrq), .dack(dack),
    .addr_lo(addr_lo), .data_out(data_out), .data_oe(data_oe), .adstb(adstb),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .eop_out(eop_out),
    .tc_flags(tc_flags)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic cfg(input int ch, input int addr, input int cnt, input int mode, input bit tm);
    @(negedge clk);
    cfg_ch = 2'(ch); cfg_addr = 16'(addr); cfg_count = 16'(cnt);
    cfg_mode = 2'(mode); cfg_to_mem = tm; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tests();
    int b, r, e, s, d;
    // reset state
    repeat (3) @(negedge clk);
    eq("R1 reset hrq", hrq, 0);
    eq("R1 reset dack", dack, 0);
    eq("R2 reset adstb", adstb, 0);
    eq("R7 reset tc", tc_flags, 0);
    rst = 1'b0;
    run(2);

    // single mode, peripheral to memory, exact handshake timing
    cfg(2, 'h1234, 2, 1, 1'b1);
    b = n_io; r = n_rise; e = n_eop;
    dreq_tb[2] = 1'b1;
    @(negedge clk);
    eq("R1 hrq one cycle after request", hrq, 1);
    eq("R1 no dack before hlda", dack, 0);
    @(negedge clk);
    eq("R1 no dack in hlda sample cycle", dack, 0);
    @(negedge clk);
    eq("R1 dack after hlda", dack, 4'b0100);
    eq("R2 adstb", adstb, 1);
    eq("R2 addr low byte", addr_lo, 'h34);
    eq("R2 addr high byte", data_out, 'h12);
    eq("R2 data_oe", data_oe, 1);
    @(negedge clk);
    eq("R14 to-memory strobes", {io_rd, mem_wr, mem_rd, io_wr}, 4'b1100);
    run(80);
    eq("R3 single byte count", n_io - b, 3);
    for (int k = 0; k < 3; k++) begin
      eq("R3 single address", io_addr[b+k], 'h1234 + k);
      eq("R3 single channel", io_ch[b+k], 2);
    end
    eq("R3 hrq released per byte", n_rise - r, 3);
    eq("R7 eop_out pulses", n_eop - e, 1);
    eq("R7 tc flag", tc_flags, 4'b0100);
    b = n_io;
    run(20);
    eq("R7 done channel idle hrq", hrq, 0);
    eq("R7 done channel no bytes", n_io - b, 0);
    dreq_tb = '0;

    // block mode, memory to peripheral, crossing a high-byte boundary
    cfg(1, 'h20FE, 3, 2, 1'b0);
    b = n_io; r = n_rise; d = n_rdio;
    dreq_tb[1] = 1'b1;
    run(4);
    dreq_tb[1] = 1'b0;
    run(40);
    eq("R4 block byte count", n_io - b, 4);
    for (int k = 0; k < 4; k++) eq("R4 block address", io_addr[b+k], 'h20FE + k);
    eq("R4 single grant", n_rise - r, 1);
    eq("R14 from-memory strobes", n_rdio - d, 4);
    eq("R7 block tc flag", tc_flags[1], 1);

    // external end of process
    cfg(3, 'h4000, 9, 2, 1'b1);
    b = n_io; e = n_eop;
    eop_in = 1'b1;
    dreq_tb[3] = 1'b1;
    run(30);
    eq("R6 eop ends after one byte", n_io - b, 1);
    eq("R6 no tc flag", tc_flags[3], 0);
    eq("R6 no eop_out", n_eop - e, 0);
    eq("R6 channel idle after eop", hrq, 0);
    eop_in = 1'b0;
    dreq_tb = '0;

    // demand mode with pause and resume
    cfg(0, 'h0500, 9, 0, 1'b1);
    b = n_io;
    stop_n = b + 2;
    dreq_tb[0] = 1'b1;
    run(40);
    eq("R5 demand pause count", n_io - b, 2);
    eq("R5 bus released on pause", hrq, 0);
    stop_n = 0;
    run(80);
    eq("R5 demand total", n_io - b, 10);
    eq("R5 resume address", io_addr[b+2], 'h0502);
    eq("R5 last address", io_addr[b+9], 'h0509);
    eq("R7 demand tc", tc_flags[0], 1);
    dreq_tb = '0;

    // fixed priority
    cfg(0, 'h0600, 1, 1, 1'b1);
    cfg(1, 'h0700, 1, 1, 1'b1);
    cfg(2, 'h0800, 1, 1, 1'b1);
    b = n_io;
    dreq_tb[2:0] = 3'b111;
    run(100);
    eq("R8 fixed count", n_io - b, 6);
    for (int k = 0; k < 6; k++) eq("R8 fixed order", io_ch[b+k], k / 2);
    dreq_tb = '0;

    // rotating priority
    rotate_en = 1'b1;
    cfg(0, 'h0600, 1, 1, 1'b1);
    cfg(1, 'h0700, 1, 1, 1'b1);
    cfg(2, 'h0800, 1, 1, 1'b1);
    b = n_io;
    dreq_tb[2:0] = 3'b111;
    run(100);
    eq("R9 rotate count", n_io - b, 6);
    for (int k = 0; k < 6; k++) eq("R9 rotate order", io_ch[b+k], k % 3);
    eq("R9 second ch0 address", io_addr[b+3], 'h0601);
    dreq_tb = '0;
    rotate_en = 1'b0;

    // mask and disable
    cfg(2, 'h0900, 0, 1, 1'b1);
    b = n_io;
    chan_mask[2] = 1'b1;
    dreq_tb[2] = 1'b1;
    run(20);
    eq("R10 masked no hrq", hrq, 0);
    en = 1'b0;
    chan_mask = '0;
    run(20);
    eq("R10 disabled no hrq", hrq, 0);
    eq("R10 no bytes while blocked", n_io - b, 0);
    en = 1'b1;
    run(30);
    eq("R10 runs once enabled", n_io - b, 1);
    eq("R10 enabled address", io_addr[b], 'h0900);
    dreq_tb = '0;

    // cascade
    cfg(3, 'h0000, 0, 3, 1'b0);
    s = n_stb; b = n_io; r = n_rise;
    dreq_tb[3] = 1'b1;
    run(8);
    eq("R11 cascade hrq", hrq, 1);
    eq("R11 cascade dack", dack, 4'b1000);
    eq("R11 cascade no adstb", n_stb - s, 0);
    eq("R11 cascade no strobes", {mem_rd, mem_wr, io_rd, io_wr}, 0);
    dreq_tb[3] = 1'b0;
    run(4);
    eq("R11 cascade release hrq", hrq, 0);
    eq("R11 cascade release dack", dack, 0);
    eq("R11 cascade no bytes", n_io - b, 0);

    // memory to memory copy
    m2m_en = 1'b1;
    cfg(0, 'h0100, 0, 2, 1'b0);
    cfg(1, 'h0200, 2, 2, 1'b0);
    s = n_src; d = n_dst;
    dreq_tb[0] = 1'b1;
    run(60);
    dreq_tb = '0;
    eq("R12 copy read count", n_src - s, 3);
    eq("R12 copy write count", n_dst - d, 3);
    for (int k = 0; k < 3; k++) begin
      eq("R12 source address", src_a[s+k], 'h0100 + k);
      eq("R12 dest address", dst_a[d+k], 'h0200 + k);
      eq("R12 copied data", dst_d[d+k], ((16'h0100 + k) & 'hFF) ^ 'h5A);
    end
    eq("R12 copy tc flag", tc_flags[1], 1);

    // memory fill with fixed source
    src_hold = 1'b1;
    cfg(0, 'h0300, 0, 2, 1'b0);
    cfg(1, 'h0400, 3, 2, 1'b0);
    s = n_src; d = n_dst;
    dreq_tb[0] = 1'b1;
    run(60);
    dreq_tb = '0;
    eq("R13 fill write count", n_dst - d, 4);
    for (int k = 0; k < 4; k++) begin
      eq("R13 fixed source", src_a[s+k], 'h0300);
      eq("R13 fill data", dst_d[d+k], 'h5A);
      eq("R13 dest address", dst_a[d+k], 'h0400 + k);
    end
    src_hold = 1'b0;
    m2m_en = 1'b0;
  endtask

  initial begin
    fork
      tests();
      begin
        #(CLK_NS * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule